// File: doc/BRIEF.md
# Phase-Accumulator Sine NCO

This block is a digital sine source that feeds a DAC. A frequency word is written into a holding register over a plain parallel write. On every sample clock a wide phase accumulator adds that word and wraps at its own width. The upper phase bits index a quarter-wave magnitude table that is built at elaboration time. The quadrant bits then mirror the table index and set the sign. The signed result is cut to its upper 14 bits and leaves the block in either two's-complement or offset-binary coding.

The tone frequency is the frequency word divided by 2^32, times the sample clock. For example, a 25 MHz clock with word 0x01000000 gives about 98 kHz. A restart control input realigns the waveform. Taking it low and then high again clears the phase register, so the following samples begin again at zero phase.

Top module: `sine_nco`

## Requirements
- R1: While `rst` is high at a clock edge, the phase register, the frequency register and `sample` all become zero.
- R2: When `fw_we` is high at an edge, `fw_data` is captured. The accumulator adds the new word from the next edge onward, and the phase value at the write is not disturbed. When `fw_we` is low, `fw_data` has no effect.
- R3: At each edge without a restart, the phase register gains the stored frequency word, modulo 2^32.
- R4: The table entry for index i (0..1023) is round(32767 * sin(pi*(i+0.5)/2048)). Let p be phase bits [31:20]. The index is p[9:0] when p[10]=0 and 1023-p[9:0] when p[10]=1. The amplitude is negated when p[11]=1.
- R5: The signed 16-bit amplitude is shifted right arithmetically by two, and the remaining 14 bits are presented.
- R6: `fmt_sel`=0 gives two's-complement. `fmt_sel`=1 gives offset binary, which is the same word with bit 13 inverted. The select is applied on the output edge.
- R7: An edge that sees `rephase` high, when it was low at the previous edge, loads phase zero in place of the sum. Accumulation then resumes from zero.
- R8: The value of the phase register between two edges is shown on `sample` after exactly two further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_we | input | 1 | Frequency word write enable |
| fw_data | input | 32 | Frequency word to store |
| rephase | input | 1 | Restart control; a low-then-high pattern clears phase |
| fmt_sel | input | 1 | Output coding: 0 two's-complement, 1 offset binary |
| sample | output | 14 | Registered sine sample for the DAC |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, 12 table-address phase bits, a 15-bit magnitude and a 14-bit output. With a full 32-bit word, a step such as 0xF3000001 wraps the accumulator every few samples, so modulo behaviour is exercised constantly. A step of 0x40000000 lands on quadrant boundaries and exercises the mirror and sign paths. With 12 address bits, a step of 0x01000000 sweeps the whole 1024-entry quarter table in 16-entry strides over a 256-sample period. The 16-to-14-bit cut makes the arithmetic rounding of negative values visible at the output.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } fmt_e;

  // Quarter-wave magnitude, sampled at the middle of each table step.
  function automatic int unsigned quarter_sine(int idx, int depth, int mag_bits);
    real ang;
    real amp;
    ang = 3.14159265358979 * (real'(idx) + 0.5) / (2.0 * real'(depth));
    amp = real'((64'd1 << mag_bits) - 64'd1);
    return int'($rtoi(amp * $sin(ang) + 0.5));
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fw_we,
  input  logic [PHASE_W-1:0] fw_data,
  input  logic               rephase,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] freq_q;
  logic [PHASE_W-1:0] phase_q;
  logic               prev_q;
  logic               restart_hit;

  assign restart_hit = rephase & ~prev_q;
  assign phase_o     = phase_q;

  // The restart detector follows the pin even in reset, so no stale edge is seen.
  always_ff @(posedge clk) prev_q <= rephase;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
    end else if (fw_we) begin
      freq_q <= fw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (restart_hit) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + freq_q;
    end
  end

  AST_FREQ_LOAD: assert property (@(posedge clk) disable iff (rst)
    fw_we |=> freq_q == $past(fw_data)); // R2
  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fw_we |=> $stable(freq_q)); // R2
  AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (rst)
    !(rephase && !prev_q) |=> phase_q == $past(phase_q) + $past(freq_q)); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rephase && !prev_q) |=> phase_q == '0); // R7

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
  parameter int LUT_AW = 12,
  parameter int MAG_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LUT_AW-1:0] phase_idx,
  output logic [MAG_W-1:0]  mag_o,
  output logic              neg_o
);
  import nco_pkg::*;

  localparam int AW    = LUT_AW - 2;
  localparam int DEPTH = 1 << AW;

  logic [MAG_W-1:0] rom [DEPTH];
  logic [AW-1:0]    rd_idx;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i] = MAG_W'(quarter_sine(i, DEPTH, MAG_W));
    end
  end

  // Odd quadrants run the table backwards.
  assign rd_idx = phase_idx[LUT_AW-2] ? ~phase_idx[AW-1:0] : phase_idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_o <= '0;
      neg_o <= 1'b0;
    end else begin
      mag_o <= rom[rd_idx];
      neg_o <= phase_idx[LUT_AW-1];
    end
  end

endmodule

// File: rtl/nco_fold_fmt.sv
module nco_fold_fmt #(
  parameter int MAG_W = 15,
  parameter int OUT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic              neg_i,
  input  nco_pkg::fmt_e     fmt_i,
  output logic [OUT_W-1:0]  word_o
);
  import nco_pkg::*;

  localparam int SW = MAG_W + 1;

  logic signed [SW-1:0] pos_v;
  logic signed [SW-1:0] sval;
  logic [OUT_W-1:0]     keep;
  logic [OUT_W-1:0]     coded;

  assign pos_v = $signed({1'b0, mag_i});
  assign sval  = neg_i ? -pos_v : pos_v;
  assign keep  = sval[SW-1 -: OUT_W];
  assign coded = (fmt_i == FMT_OFFSET) ? {~keep[OUT_W-1], keep[OUT_W-2:0]} : keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
    end else begin
      word_o <= coded;
    end
  end

endmodule

// File: rtl/sine_nco.sv
module sine_nco #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 12,
  parameter int MAG_W   = 15,
  parameter int OUT_W   = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fw_we,
  input  logic [PHASE_W-1:0] fw_data,
  input  logic               rephase,
  input  logic               fmt_sel,
  output logic [OUT_W-1:0]   sample
);
  import nco_pkg::*;

  logic [PHASE_W-1:0] phase;
  logic [MAG_W-1:0]   mag;
  logic               neg;

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .fw_we   (fw_we),
    .fw_data (fw_data),
    .rephase (rephase),
    .phase_o (phase)
  );

  nco_quarter_rom #(.LUT_AW(LUT_AW), .MAG_W(MAG_W)) u_rom (
    .clk       (clk),
    .rst       (rst),
    .phase_idx (phase[PHASE_W-1 -: LUT_AW]),
    .mag_o     (mag),
    .neg_o     (neg)
  );

  nco_fold_fmt #(.MAG_W(MAG_W), .OUT_W(OUT_W)) u_fold (
    .clk    (clk),
    .rst    (rst),
    .mag_i  (mag),
    .neg_i  (neg),
    .fmt_i  (fmt_e'(fmt_sel)),
    .word_o (sample)
  );

endmodule

// File: tb/sine_nco_tb.sv
`timescale 1ns/1ps
module sine_nco_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fw_we = 1'b0;
  logic [31:0] fw_data = '0;
  logic        rephase = 1'b1;
  logic        fmt_sel = 1'b0;
  logic [13:0] sample;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  typedef struct { bit vld; int exp; string tag; } item_t;
  item_t sbq[$];

  localparam real PI = 3.14159265358979;

  always #2 clk = ~clk;

  sine_nco u_dut (
    .clk(clk), .rst(rst), .fw_we(fw_we), .fw_data(fw_data),
    .rephase(rephase), .fmt_sel(fmt_sel), .sample(sample)
  );

  function automatic int expect_sample(logic [31:0] ph, bit fmt);
    int p, a, idx, mag, v, t, c;
    p   = int'(ph[31:20]);
    a   = p & 1023;
    idx = ((p & 1024) != 0) ? 1023 - a : a;
    mag = $rtoi(32767.0 * $sin(PI * (real'(idx) + 0.5) / 2048.0) + 0.5);
    v   = ((p & 2048) != 0) ? -mag : mag;
    t   = v >>> 2;
    c   = t & 'h3FFF;
    if (fmt) c = c ^ 'h2000;
    return c;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: advances on each edge from the inputs driven before it.
  logic [31:0] m_ph = '0, m_fr = '0, m_d1 = '0;
  bit m_prev = 1'b1;
  int warm = 0;
  always @(posedge clk) begin
    item_t it;
    bit hit;
    it.tag = cur_tag;
    if (rst) begin
      m_ph = '0; m_fr = '0; m_d1 = '0; m_prev = rephase; warm = 0;
      it.vld = 0; it.exp = 0;
    end else begin
      hit = rephase && !m_prev;
      it.vld = (warm >= 1);                      // R8: two-edge pipeline
      it.exp = expect_sample(m_d1, fmt_sel);     // R4 R5 R6
      if (warm < 4) warm++;
      m_d1 = m_ph;
      m_ph = hit ? 32'd0 : m_ph + m_fr;          // R3 R7
      if (fw_we) m_fr = fw_data;                 // R2
      m_prev = rephase;
    end
    sbq.push_back(it);
  end

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      if (it.vld && !finished) check(it.tag, int'(sample), it.exp);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(logic [31:0] w);
    fw_data = w; fw_we = 1'b1;
    tick(1);
    fw_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    tick(4);
    check("R1 reset output", int'(sample), 0);
    rst = 1'b0;

    cur_tag = "R4 R5 R8 word 0x01000000";
    write_word(32'h0100_0000);
    tick(300);

    cur_tag = "R6 offset binary";
    fmt_sel = 1'b1;
    tick(100);
    fmt_sel = 1'b0;

    cur_tag = "R2 data without write enable ignored";
    fw_data = 32'h5555_5555;
    tick(50);

    cur_tag = "R3 wrap with large word";
    write_word(32'hF300_0001);
    tick(200);

    cur_tag = "R4 quadrant boundaries";
    write_word(32'h4000_0000);
    tick(40);

    cur_tag = "R7 restart";
    write_word(32'h0123_4567);
    tick(13);
    rephase = 1'b0;
    tick(3);
    rephase = 1'b1;
    tick(30);

    cur_tag = "R7 low level does not clear";
    rephase = 1'b0;
    tick(20);
    rephase = 1'b1;
    tick(10);

    cur_tag = "R2 write mid-run keeps phase";
    write_word(32'h0001_2345);
    tick(60);
    fmt_sel = 1'b1;
    write_word(32'hC000_0000);
    tick(30);

    cur_tag = "R1 reset mid-run";
    rst = 1'b1;
    tick(3);
    check("R1 reset mid-run output", int'(sample), 0);
    rst = 1'b0;
    fmt_sel = 1'b0;
    cur_tag = "R1 R3 after reset word cleared";
    tick(20);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule